// File: doc/BRIEF.md
# Serial Baud-Rate Retiming Bridge

The bridge accepts an asynchronous serial byte stream from a host and sends the same bytes on to a timing-sensitive device. The host's bit edges may wander and its characters may arrive with uneven gaps. Output bit timing is produced only by a divider on the local reference clock, so every output bit has the same length regardless of how the host behaved. All of it is fixed-function logic, with no processor or firmware.

Inside, an oversampling receiver turns each incoming character into a byte. A shallow elastic FIFO absorbs the difference in timing between the two sides. A transmit serializer on the reference clock drains the FIFO. The FIFO is kept small on purpose, because a deep buffer adds latency that can make either end of the link time out. A clear-to-send output tells the host to pause before the FIFO fills. Framing faults and overruns are latched in a two-bit sticky status output.

Top module: `serial_retime_bridge`

## Requirements
- R1: Both directions use 10-bit characters: a low start bit, 8 data bits sent least significant bit first, and a high stop bit. `dev_txd` sits high whenever nothing is being sent.
- R2: Every bit on `dev_txd` lasts exactly `TX_BIT_CYCLES` clock cycles. This count comes only from the local clock and is unaffected by host timing.
- R3: While the FIFO holds data, the next character's start bit follows the previous stop bit directly, with no idle bit between them. A byte that arrives while the transmitter is idle begins within a few cycles.
- R4: The receiver samples `host_rxd` at `OVS_RATE` ticks per bit and checks the start bit again at mid-bit. A low pulse that has ended by mid-bit is ignored, so no byte is produced and no status bit is set.
- R5: A character whose stop bit reads low is not queued, and `err_flags[0]` (framing) is set. It stays set until reset.
- R6: A good character that arrives while the FIFO holds `FIFO_DEPTH` bytes is discarded, and `err_flags[1]` (overrun) is set. It stays set until reset. Queued bytes are never overwritten, and bytes leave in arrival order.
- R7: `host_cts` goes low once FIFO occupancy reaches `FIFO_DEPTH-1`. It goes high again once occupancy falls to 1 or below, and keeps its value in between.
- R8: After reset, `dev_txd` and `host_cts` are high and `err_flags` is 0.
- R9: A host that starts a character only while `host_cts` is high never causes an overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local reference clock; sets both the receive sampling and the transmit bit timing |
| rst | input | 1 | Synchronous active-high reset |
| host_rxd | input | 1 | Asynchronous serial data from the host, idle high |
| host_cts | output | 1 | Clear-to-send toward the host; high means the host may send |
| dev_txd | output | 1 | Retimed serial data toward the device, idle high |
| err_flags | output | 2 | Sticky status: bit 1 overrun, bit 0 framing error |

## Verification
The assertions check on every cycle the properties that hold everywhere:
- occupancy never exceeds the depth;
- the clear-to-send thresholds;
- a bad stop bit or a byte arriving at a full FIFO moves the matching sticky flag and never adds an entry;
- every low run on the device line is a whole number of bit periods.

The bench's scenarios are needed for the rest:
- the byte values and their order;
- back-to-back framing with no idle gap;
- glitch rejection;
- the exact overrun pattern when a host ignores clear-to-send and outruns the device;
- the absence of overruns when the host honours clear-to-send.

All of these depend on a reference model of what the host sent.

// File: rtl/retime_pkg.sv
package retime_pkg;

    localparam int DATA_BITS = 8;

    typedef logic [DATA_BITS-1:0] byte_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    // One received character, presented for a single cycle
    typedef struct packed {
        logic  valid;
        logic  stop_ok;
        byte_t data;
    } rx_char_t;

    // Sticky status; packs as {overrun, frame_err}
    typedef struct packed {
        logic overrun;
        logic frame_err;
    } status_t;

    // Shift one line sample into the top of a byte (LSB-first framing)
    function automatic byte_t shift_in(byte_t cur, logic b);
        return {b, cur[DATA_BITS-1:1]};
    endfunction

endpackage

// File: rtl/retime_rx.sv
module retime_rx
    import retime_pkg::*;
#(
    parameter int OVS_DIV  = 27,
    parameter int OVS_RATE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rxd_async,
    output rx_char_t char_o
);
    localparam int DIV_W = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;
    localparam int SMP_W = $clog2(OVS_RATE);
    localparam int BIT_W = $clog2(DATA_BITS);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OVS_DIV - 1);
    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(OVS_RATE - 1);
    localparam logic [SMP_W-1:0] SMP_MID  = SMP_W'(OVS_RATE / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    logic [1:0]       sync_q;
    logic             rxd;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic [SMP_W-1:0] smp_q;
    logic [BIT_W-1:0] bit_q;
    byte_t            shreg_q;
    rx_state_e        state_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd_async};
    end
    assign rxd  = sync_q[1];
    assign tick = (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            div_q   <= '0;
            smp_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            char_o  <= '0;
        end else begin
            char_o.valid <= 1'b0;
            if (state_q == RX_IDLE || tick) div_q <= '0;
            else                            div_q <= div_q + 1'b1;

            unique case (state_q)
                RX_IDLE: begin
                    if (!rxd) begin
                        state_q <= RX_START;
                        smp_q   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (smp_q == SMP_MID) begin
                            smp_q   <= '0;
                            bit_q   <= '0;
                            state_q <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            smp_q <= smp_q + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (smp_q == SMP_LAST) begin
                            smp_q   <= '0;
                            shreg_q <= shift_in(shreg_q, rxd);
                            if (bit_q == BIT_LAST) state_q <= RX_STOP;
                            else                   bit_q   <= bit_q + 1'b1;
                        end else begin
                            smp_q <= smp_q + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (smp_q == SMP_LAST) begin
                            smp_q          <= '0;
                            char_o.valid   <= 1'b1;
                            char_o.stop_ok <= rxd;
                            char_o.data    <= shreg_q;
                            state_q        <= RX_IDLE;
                        end else begin
                            smp_q <= smp_q + 1'b1;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/retime_fifo.sv
module retime_fifo
    import retime_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  byte_t            wdata,
    input  logic             pop,
    output byte_t            rdata,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    byte_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic             do_push, do_pop;

    assign do_push = push && (count != CNT_FULL);
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/retime_flow.sv
module retime_flow #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    output logic             cts
);
    localparam logic [CNT_W-1:0] OFF_AT = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ON_AT  = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)                  cts <= 1'b1;
        else if (count >= OFF_AT) cts <= 1'b0;
        else if (count <= ON_AT)  cts <= 1'b1;
    end
endmodule

// File: rtl/retime_tx.sv
module retime_tx
    import retime_pkg::*;
#(
    parameter int BIT_CYCLES = 434
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  have_data,
    input  byte_t data_i,
    output logic  pop,
    output logic  txd
);
    localparam int CNT_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam int BIT_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYCLES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    tx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    byte_t            shreg_q;
    logic             bit_end;

    assign bit_end = (cnt_q == CNT_LAST);
    assign pop     = have_data && ((state_q == TX_IDLE) || (state_q == TX_STOP && bit_end));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            txd     <= 1'b1;
        end else begin
            if (state_q == TX_IDLE || bit_end) cnt_q <= '0;
            else                               cnt_q <= cnt_q + 1'b1;

            unique case (state_q)
                TX_IDLE: begin
                    if (pop) begin
                        shreg_q <= data_i;
                        txd     <= 1'b0;
                        state_q <= TX_START;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        txd     <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                        bit_q   <= '0;
                        state_q <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        if (bit_q == BIT_LAST) begin
                            txd     <= 1'b1;
                            state_q <= TX_STOP;
                        end else begin
                            txd     <= shreg_q[0];
                            shreg_q <= shreg_q >> 1;
                            bit_q   <= bit_q + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        if (pop) begin
                            shreg_q <= data_i;
                            txd     <= 1'b0;
                            state_q <= TX_START;
                        end else begin
                            state_q <= TX_IDLE;
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_retime_bridge.sv
module serial_retime_bridge
    import retime_pkg::*;
#(
    parameter int OVS_DIV       = 27,
    parameter int OVS_RATE      = 16,
    parameter int TX_BIT_CYCLES = 434,
    parameter int FIFO_DEPTH    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_rxd,
    output logic       host_cts,
    output logic       dev_txd,
    output logic [1:0] err_flags
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(FIFO_DEPTH);

    rx_char_t         rx_char;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_full;
    logic             wr_en;
    logic             rd_en;
    byte_t            rd_data;
    status_t          status_q;

    assign fifo_full = (fifo_count == FULL_AT);
    assign wr_en     = rx_char.valid && rx_char.stop_ok && !fifo_full;

    retime_rx #(
        .OVS_DIV  (OVS_DIV),
        .OVS_RATE (OVS_RATE)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rxd_async (host_rxd),
        .char_o    (rx_char)
    );

    retime_fifo #(
        .DEPTH (FIFO_DEPTH),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_en),
        .wdata (rx_char.data),
        .pop   (rd_en),
        .rdata (rd_data),
        .count (fifo_count)
    );

    retime_flow #(
        .DEPTH (FIFO_DEPTH),
        .CNT_W (CNT_W)
    ) u_flow (
        .clk   (clk),
        .rst   (rst),
        .count (fifo_count),
        .cts   (host_cts)
    );

    retime_tx #(
        .BIT_CYCLES (TX_BIT_CYCLES)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .have_data (fifo_count != '0),
        .data_i    (rd_data),
        .pop       (rd_en),
        .txd       (dev_txd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (rx_char.valid) begin
            if (!rx_char.stop_ok) status_q.frame_err <= 1'b1;
            else if (fifo_full)   status_q.overrun   <= 1'b1;
        end
    end

    assign err_flags = status_q;
endmodule

// File: rtl/retime_checks.sv
module retime_checks #(
    parameter int FIFO_DEPTH    = 4,
    parameter int TX_BIT_CYCLES = 434,
    parameter int CNT_W         = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             host_cts,
    input logic             dev_txd,
    input logic [1:0]       err_flags,
    input logic             rx_valid,
    input logic             rx_stop_ok,
    input logic [CNT_W-1:0] fifo_count
);
    localparam int PH_W = (TX_BIT_CYCLES > 1) ? $clog2(TX_BIT_CYCLES) : 1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(TX_BIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] C_FULL  = CNT_W'(FIFO_DEPTH);
    localparam logic [CNT_W-1:0] C_OFF   = CNT_W'(FIFO_DEPTH - 1);
    localparam logic [CNT_W-1:0] C_ON    = CNT_W'(1);

    // Length, modulo one bit period, of the current dev_txd level
    logic            txd_d;
    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            txd_d <= 1'b1;
            ph_q  <= '0;
        end else begin
            txd_d <= dev_txd;
            if (dev_txd != txd_d)  ph_q <= PH_W'(1);
            else if (ph_q == PH_LAST) ph_q <= '0;
            else                   ph_q <= ph_q + 1'b1;
        end
    end

    p_low_run_whole_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (dev_txd && !txd_d) |-> (ph_q == '0));

    p_bad_stop_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_stop_ok) |=> (err_flags[0] && fifo_count <= $past(fifo_count)));

    p_frame_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_flags[0] |=> err_flags[0]);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= C_FULL);

    p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_stop_ok && fifo_count == C_FULL) |=> (err_flags[1] && fifo_count <= $past(fifo_count)));

    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err_flags[1] |=> err_flags[1]);

    p_cts_off_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_count >= C_OFF) |=> !host_cts);

    p_cts_on_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_count <= C_ON) |=> host_cts);
endmodule

bind serial_retime_bridge retime_checks #(
    .FIFO_DEPTH    (FIFO_DEPTH),
    .TX_BIT_CYCLES (TX_BIT_CYCLES),
    .CNT_W         (CNT_W)
) u_checks (
    .clk        (clk),
    .rst        (rst),
    .host_cts   (host_cts),
    .dev_txd    (dev_txd),
    .err_flags  (err_flags),
    .rx_valid   (rx_char.valid),
    .rx_stop_ok (rx_char.stop_ok),
    .fifo_count (fifo_count)
);

// File: tb/serial_retime_bridge_bench.sv
module serial_retime_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 16;   // host bit, clocks (OVS_DIV=1, 16x)
    localparam int TXB        = 41;   // device bit, clocks
    localparam int DEPTH      = 4;
    localparam int FRAME      = 10 * TXB;
    localparam int READY_AGE  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rxd = 1'b1;
    logic       host_cts;
    logic       dev_txd;
    logic [1:0] err_flags;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_retime_bridge #(
        .OVS_DIV       (1),
        .OVS_RATE      (16),
        .TX_BIT_CYCLES (TXB),
        .FIFO_DEPTH    (DEPTH)
    ) u_serial_retime_bridge (
        .clk       (clk),
        .rst       (rst),
        .host_rxd  (host_rxd),
        .host_cts  (host_cts),
        .dev_txd   (dev_txd),
        .err_flags (err_flags)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] q[$];       // bytes accepted, not yet started on the device line
    int         qt[$];      // cycle each byte was accepted
    bit         m_cts  = 1;
    bit         m_ferr = 0;
    bit         m_ovr  = 0;
    int         quiet  = 0;
    int         cyc    = 0;
    int         accepted = 0;
    int         frames   = 0;

    function void cts_update();
        if (q.size() >= DEPTH - 1) m_cts = 0;
        else if (q.size() <= 1)    m_cts = 1;
    endfunction

    task automatic host_send(input logic [7:0] b, input bit good_stop,
                             input bit wait_cts, input int start_jit);
        if (wait_cts) while (host_cts !== 1'b1) @(negedge clk);
        host_rxd = 1'b0;
        repeat (HB + start_jit) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            host_rxd = b[i];
            repeat (HB) @(negedge clk);
        end
        host_rxd = good_stop;
        repeat (HB / 2) @(negedge clk);
        if (!good_stop)            m_ferr = 1;
        else if (q.size() == DEPTH) m_ovr = 1;
        else begin
            q.push_back(b);
            qt.push_back(cyc);
            accepted++;
        end
        cts_update();
        quiet = 0;
        repeat (HB - HB / 2) @(negedge clk);
        host_rxd = 1'b1;
    endtask

    // ---------------- device-line monitor ----------------
    int       mon_pos   = -1;
    logic [9:0] mon_frame;
    int       idle_wait = 0;

    task automatic start_frame();
        logic [7:0] b;
        b = q.pop_front();
        void'(qt.pop_front());
        mon_frame = {1'b1, b, 1'b0};
        mon_pos   = 0;
        frames++;
        cts_update();
        quiet = 0;
    endtask

    always @(posedge clk) begin
        #(CLK_PERIOD / 4);
        cyc++;
        if (rst) begin
            mon_pos   = -1;
            idle_wait = 0;
        end else begin
            quiet++;
            if (mon_pos >= 0) begin
                mon_pos++;
                if (mon_pos == FRAME) begin
                    if (q.size() > 0 && (cyc - qt[0]) >= READY_AGE) begin
                        check_eq("R3", "start bit directly after stop", int'(dev_txd), 0);
                        if (dev_txd == 1'b0) start_frame();
                        else mon_pos = -1;
                    end else if (q.size() > 0 && dev_txd == 1'b0) begin
                        start_frame();
                    end else begin
                        check_eq("R1", "line high after stop bit", int'(dev_txd), 1);
                        mon_pos   = -1;
                        idle_wait = 0;
                    end
                end else begin
                    check_eq("R2", "device bit level", int'(dev_txd), int'(mon_frame[mon_pos / TXB]));
                end
            end else begin
                if (dev_txd == 1'b0) begin
                    if (q.size() == 0) check_eq("R4", "unexpected frame start (queue size)", 1, 0);
                    else               start_frame();
                end else if (q.size() > 0) begin
                    idle_wait++;
                    if (idle_wait == HB) check_eq("R3", "queued byte left waiting (idle cycles)", idle_wait, 0);
                end else begin
                    idle_wait = 0;
                end
            end
            if (quiet >= 6) begin
                check_eq("R7", "host_cts vs model", int'(host_cts), int'(m_cts));
                check_eq("R5", "framing flag vs model", int'(err_flags[0]), int'(m_ferr));
                check_eq("R6", "overrun flag vs model", int'(err_flags[1]), int'(m_ovr));
            end
        end
    end

    task automatic drain();
        while (!(q.size() == 0 && mon_pos < 0)) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] fixed[6];
        fixed = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A};

        repeat (5) @(negedge clk);
        check_eq("R8", "dev_txd in reset", int'(dev_txd), 1);
        check_eq("R8", "host_cts in reset", int'(host_cts), 1);
        check_eq("R8", "err_flags in reset", int'(err_flags), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R8", "dev_txd after reset", int'(dev_txd), 1);

        // R4: short low pulses are not characters
        host_rxd = 1'b0; repeat (3) @(negedge clk); host_rxd = 1'b1;
        repeat (200) @(negedge clk);
        host_rxd = 1'b0; repeat (HB / 2 - 2) @(negedge clk); host_rxd = 1'b1;
        repeat (300) @(negedge clk);
        check_eq("R4", "no frame after glitches", frames, 0);
        check_eq("R4", "no status after glitches", int'(err_flags), 0);
        check_eq("R4", "line idle after glitches", int'(dev_txd), 1);

        // R1/R2: fixed patterns, one at a time
        foreach (fixed[i]) begin
            host_send(fixed[i], 1'b1, 1'b1, 0);
            drain();
        end
        check_eq("R1", "frames for single bytes", frames, 6);

        // R3/R7/R9: jittered burst honouring clear-to-send
        for (int i = 0; i < 14; i++) begin
            host_send(8'($urandom_range(255)), 1'b1, 1'b1, int'($urandom_range(2)) - 1);
            repeat ($urandom_range(20)) @(negedge clk);
        end
        drain();
        check_eq("R9", "no overrun when host obeys cts", int'(err_flags[1]), 0);
        check_eq("R3", "frames after burst", frames, accepted);

        // R5: bad stop bit dropped, next good byte still passes
        host_send(8'h3C, 1'b0, 1'b1, 0);
        repeat (2 * HB) @(negedge clk);
        host_send(8'h81, 1'b1, 1'b1, 0);
        drain();
        check_eq("R5", "framing flag set", int'(err_flags[0]), 1);
        check_eq("R5", "bad byte not forwarded", frames, accepted);

        // R6: host ignores clear-to-send and outruns the device
        for (int i = 0; i < 10; i++)
            host_send(8'(8'h10 + i), 1'b1, 1'b0, 0);
        drain();
        check_eq("R6", "overrun flag set", int'(err_flags[1]), 1);
        check_eq("R6", "model saw an overrun", int'(m_ovr), 1);
        check_eq("R6", "forwarded count", frames, accepted);

        // R5/R6: flags stay set through further good traffic
        host_send(8'hC3, 1'b1, 1'b1, 0);
        drain();
        check_eq("R6", "overrun still set", int'(err_flags[1]), 1);
        check_eq("R5", "framing still set", int'(err_flags[0]), 1);
        check_eq("R7", "cts high when empty", int'(host_cts), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule